// File: doc/BRIEF.md
# Auto transmit/receive GPIO controller

This block drives two banks of general-purpose pins for a radio, one bank on the receive side and one on the transmit side. It is a 16-bit register slave. Each output pin takes its value from one of three places: a register that software writes, a debug register, or a stored pattern. The pattern source follows the live radio condition. The controller keeps a small state machine that tracks the transmit-active and receive-active status inputs. Its current state picks one of four stored pattern words for each bank. Pins switch between patterns on their own as the radio changes mode, with no software in the loop.

Software sets up each bank through four kinds of register: a data word, a direction word, a two-word select map and a debug word. It also loads eight pattern words, one for each pair of radio state and bank. A read of a bank's data address returns the pin input levels after a two-flop synchronizer, not the stored value. Reset clears every register, so all pins start as inputs with their outputs at zero.

State machine: four states, `RS_IDLE`, `RS_TXONLY`, `RS_RXONLY` and `RS_DUPLEX`. On every clock edge the machine moves from any state to the state that `{tx_active, rx_active}` encodes. The transitions are *go-idle* (00), *go-tx* (10), *go-rx* (01) and *go-duplex* (11). A state can loop back to itself.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, every output enable and every pin output is 0, and every readable address returns 0 until new pin levels reach the synchronizer.
- R2: Address bit 0 is ignored. A write or read at an odd byte address reaches the same register as the even address below it.
- R3: Direction bit i = 1 asserts output enable i of that bank. Direction bit 0 clears the enable and forces pin output i to 0, whatever the select field holds.
- R4: For an output pin, select code 0 drives the pin from the same bit of the bank's data register.
- R5: For an output pin, select code 1 drives the pin from the same bit of the pattern word that matches the current radio state and the pin's bank.
- R6: For an output pin, select codes 2 and 3 both drive the pin from the same bit of the bank's debug register.
- R7: The radio state is `{tx_active, rx_active}`: 00 idle, 10 transmit only, 01 receive only, 11 duplex. The pattern words sit at byte addresses 0x20 + 4*s + 2*b. Here s is 0 for idle, 1 for transmit only, 2 for receive only and 3 for duplex, and b is 0 for the receive bank and 1 for the transmit bank.
- R8: A change on the status inputs reaches the pattern-driven pins on the first clock edge after the change. A register write takes effect on the edge that samples it. With neither event, the pin outputs and enables hold.
- R9: A read at byte address 0x00 (receive bank) or 0x02 (transmit bank) returns that bank's pin inputs as they were two clock edges earlier.
- R10: Other register addresses in the 0x00–0x1F range: 0x04/0x06 direction, 0x08/0x0A select low, 0x0C/0x0E debug, 0x10/0x12 select high (receive/transmit). Each reads back the last value written. Addresses 0x14–0x1F and 0x30–0x3F read 0, and writes to them change nothing.
- R11: The select code of pin i sits in bits [2i+1:2i] of the select-low word for i < 8, and in bits [2(i-8)+1:2(i-8)] of the select-high word for i >= 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tx_active | input | 1 | Transmit path active |
| rx_active | input | 1 | Receive path active |
| rx_pin_in | input | 16 | Receive-bank pin input levels |
| tx_pin_in | input | 16 | Transmit-bank pin input levels |
| rx_pin_out | output | 16 | Receive-bank pin output values |
| rx_pin_oe | output | 16 | Receive-bank output enables |
| tx_pin_out | output | 16 | Transmit-bank pin output values |
| tx_pin_oe | output | 16 | Transmit-bank output enables |

## Verification
The bench steps the status inputs through all four radio conditions while pins are set to the pattern source, and checks the pins on each edge. A design that decoded the status pair the wrong way round would swap the transmit-only and receive-only patterns. A design with an extra register stage would lag the status by one cycle. Random select maps cover codes 2 and 3 and pins above 7, which catches a debug route wired to only one code or a select-high word mapped onto the wrong pins. Writes to odd and unused addresses are followed by full readback, so a design that decoded bit 0, or let an unused slot alias a real register, would corrupt a stored word. Random pin inputs read through the data addresses expose a synchronizer with the wrong depth.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_TXONLY = 2'd1,
        RS_RXONLY = 2'd2,
        RS_DUPLEX = 2'd3
    } radio_state_t;

    localparam logic [1:0] SRC_SOFT = 2'd0;
    localparam logic [1:0] SRC_AUTO = 2'd1;

    localparam int NUM_BANKS  = 2;
    localparam int NUM_STATES = 4;

endpackage

// File: rtl/atr_state_fsm.sv
module atr_state_fsm
    import atr_gpio_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_active_i,
    input  logic         rx_active_i,
    output radio_state_t state_o,
    output logic [1:0]   pat_idx_o
);

    radio_state_t state_d;
    radio_state_t state_q;

    // Next state: every state may move to any other on one edge.
    always_comb begin
        unique case ({tx_active_i, rx_active_i})
            2'b00:   state_d = RS_IDLE;    // go-idle
            2'b10:   state_d = RS_TXONLY;  // go-tx
            2'b01:   state_d = RS_RXONLY;  // go-rx
            default: state_d = RS_DUPLEX;  // go-duplex
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Output: pattern slot chosen by the current state.
    always_comb begin
        unique case (state_q)
            RS_IDLE:   pat_idx_o = 2'd0;
            RS_TXONLY: pat_idx_o = 2'd1;
            RS_RXONLY: pat_idx_o = 2'd2;
            RS_DUPLEX: pat_idx_o = 2'd3;
            default:   pat_idx_o = 2'd0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/atr_in_sync.sv
module atr_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/atr_pin_mux.sv
module atr_pin_mux
    import atr_gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   io_i,
    input  logic [W-1:0]   ddr_i,
    input  logic [2*W-1:0] sel_i,
    input  logic [W-1:0]   dbg_i,
    input  logic [W-1:0]   pat_i,
    output logic [W-1:0]   out_o,
    output logic [W-1:0]   oe_o
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [1:0] code;
        logic       src;

        assign code = sel_i[2*i +: 2];

        always_comb begin
            unique case (code)
                SRC_SOFT: src = io_i[i];
                SRC_AUTO: src = pat_i[i];
                default:  src = dbg_i[i];
            endcase
        end

        assign out_o[i] = ddr_i[i] & src;
    end

    assign oe_o = ddr_i;

endmodule

// File: rtl/atr_gpio_regs.sv
module atr_gpio_regs
    import atr_gpio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [DATA_W-1:0]                    wdata_i,
    output logic [DATA_W-1:0]                    rdata_o,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]     sync_i,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]     io_o,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]     ddr_o,
    output logic [NUM_BANKS-1:0][2*DATA_W-1:0]   sel_o,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]     dbg_o,
    output logic [NUM_STATES-1:0][NUM_BANKS-1:0][DATA_W-1:0] pat_o
);

    localparam int REGION_BIT = ADDR_W - 1;

    logic       region;
    logic [3:0] idx;
    logic       bank;
    logic       unused_addr_bits;

    assign region = addr_i[REGION_BIT];
    assign idx    = addr_i[4:1];
    assign bank   = idx[0];
    assign unused_addr_bits = addr_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_o  <= '0;
            ddr_o <= '0;
            sel_o <= '0;
            dbg_o <= '0;
            pat_o <= '0;
        end else if (we_i) begin
            if (!region) begin
                if (!idx[3]) begin
                    case (idx[2:1])
                        2'd0:    io_o[bank]                <= wdata_i;
                        2'd1:    ddr_o[bank]               <= wdata_i;
                        2'd2:    sel_o[bank][DATA_W-1:0]   <= wdata_i;
                        default: dbg_o[bank]               <= wdata_i;
                    endcase
                end else if (idx[2:1] == 2'd0) begin
                    sel_o[bank][2*DATA_W-1:DATA_W] <= wdata_i;
                end
            end else if (!idx[3]) begin
                pat_o[idx[2:1]][bank] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (!region) begin
            if (!idx[3]) begin
                case (idx[2:1])
                    2'd0:    rdata_o = sync_i[bank];
                    2'd1:    rdata_o = ddr_o[bank];
                    2'd2:    rdata_o = sel_o[bank][DATA_W-1:0];
                    default: rdata_o = dbg_o[bank];
                endcase
            end else if (idx[2:1] == 2'd0) begin
                rdata_o = sel_o[bank][2*DATA_W-1:DATA_W];
            end
        end else if (!idx[3]) begin
            rdata_o = pat_o[idx[2:1]][bank];
        end
    end

endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
    import atr_gpio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [DATA_W-1:0] rx_pin_in,
    input  logic [DATA_W-1:0] tx_pin_in,
    output logic [DATA_W-1:0] rx_pin_out,
    output logic [DATA_W-1:0] rx_pin_oe,
    output logic [DATA_W-1:0] tx_pin_out,
    output logic [DATA_W-1:0] tx_pin_oe
);

    radio_state_t state_q;
    logic [1:0]   pat_idx;

    logic [NUM_BANKS-1:0][DATA_W-1:0]   pin_in;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   sync_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   io_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   ddr_q;
    logic [NUM_BANKS-1:0][2*DATA_W-1:0] sel_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   dbg_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   pin_out;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   pin_oe;
    logic [NUM_STATES-1:0][NUM_BANKS-1:0][DATA_W-1:0] pat_q;

    assign pin_in[0] = rx_pin_in;
    assign pin_in[1] = tx_pin_in;

    atr_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active_i (tx_active),
        .rx_active_i (rx_active),
        .state_o     (state_q),
        .pat_idx_o   (pat_idx)
    );

    atr_gpio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .sync_i  (sync_q),
        .io_o    (io_q),
        .ddr_o   (ddr_q),
        .sel_o   (sel_q),
        .dbg_o   (dbg_q),
        .pat_o   (pat_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        atr_in_sync #(.W(DATA_W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pin_in[b]),
            .q_o   (sync_q[b])
        );

        atr_pin_mux #(.W(DATA_W)) u_mux (
            .io_i  (io_q[b]),
            .ddr_i (ddr_q[b]),
            .sel_i (sel_q[b]),
            .dbg_i (dbg_q[b]),
            .pat_i (pat_q[pat_idx][b]),
            .out_o (pin_out[b]),
            .oe_o  (pin_oe[b])
        );
    end

    assign rx_pin_out = pin_out[0];
    assign rx_pin_oe  = pin_oe[0];
    assign tx_pin_out = pin_out[1];
    assign tx_pin_oe  = pin_oe[1];

endmodule

// File: rtl/atr_gpio_checker.sv
module atr_gpio_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_active,
    input logic              rx_active,
    input logic [DATA_W-1:0] rx_pin_in,
    input logic [DATA_W-1:0] rx_pin_out,
    input logic [DATA_W-1:0] rx_pin_oe,
    input logic [DATA_W-1:0] tx_pin_out,
    input logic [DATA_W-1:0] tx_pin_oe,
    input logic [1:0]        state_q
);

    logic [ADDR_W-2:0] word;
    logic [1:0]        up_cnt;
    logic              unused_addr_bit;

    assign word = bus_addr[ADDR_W-1:1];
    assign unused_addr_bit = bus_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               up_cnt <= 2'd0;
        else if (up_cnt != 2'd2)  up_cnt <= up_cnt + 2'd1;
    end

    // R1: enables are clear on the first edge that sees reset released
    p_reset_oe_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (rx_pin_oe == '0 && tx_pin_oe == '0));

    // R3: a direction write shows up on the enables one edge later
    p_ddr_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == 5'd2) |=> (rx_pin_oe == $past(bus_wdata)));

    p_ddr_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == 5'd3) |=> (tx_pin_oe == $past(bus_wdata)));

    // R7: state tracks the status pair of the previous cycle
    p_state_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (state_q == $past({rx_active, tx_active})));

    // R8: no write and no status change keeps every pin steady
    p_pins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && state_q == {rx_active, tx_active}) |=>
            ($stable(rx_pin_out) && $stable(tx_pin_out) &&
             $stable(rx_pin_oe) && $stable(tx_pin_oe)));

    // R9: receive-bank data readback is the pin level two edges back
    p_io_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2 && word == 5'd0) |-> (bus_rdata == $past(rx_pin_in, 2)));

endmodule

bind atr_gpio_ctrl atr_gpio_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_atr_gpio_ctrl.sv
module tb_atr_gpio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tx_active = 1'b0;
    logic          rx_active = 1'b0;
    logic [DW-1:0] rx_pin_in = '0;
    logic [DW-1:0] tx_pin_in = '0;
    logic [DW-1:0] rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe;

    atr_gpio_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_active(tx_active), .rx_active(rx_active),
        .rx_pin_in(rx_pin_in), .tx_pin_in(tx_pin_in),
        .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe),
        .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Bench model of the registers, built from the requirements
    logic [DW-1:0]   m_io  [2];
    logic [DW-1:0]   m_ddr [2];
    logic [DW-1:0]   m_dbg [2];
    logic [DW-1:0]   m_s1  [2];
    logic [DW-1:0]   m_s2  [2];
    logic [2*DW-1:0] m_sel [2];
    logic [DW-1:0]   m_pat [4][2];
    int              m_state;

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            m_io[b] = '0; m_ddr[b] = '0; m_dbg[b] = '0;
            m_s1[b] = '0; m_s2[b] = '0; m_sel[b] = '0;
            for (int s = 0; s < 4; s++) m_pat[s][b] = '0;
        end
        m_state = 0;
    endtask

    // R7 state numbering
    function automatic int state_of(logic tx, logic rx);
        if (!tx && !rx) return 0;
        if (tx && !rx)  return 1;
        if (!tx && rx)  return 2;
        return 3;
    endfunction

    // R3 R4 R5 R6 R11
    function automatic logic [DW-1:0] exp_out(int b);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) begin
            logic [1:0] f;
            logic       s;
            f = m_sel[b][2*i +: 2];
            if (f == 2'd0)      s = m_io[b][i];
            else if (f == 2'd1) s = m_pat[m_state][b][i];
            else                s = m_dbg[b][i];
            r[i] = m_ddr[b][i] & s;
        end
        return r;
    endfunction

    // R2 R9 R10 address map
    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        int w, b;
        w = int'(a[4:1]);
        b = w % 2;
        if (!a[5]) begin
            case (w)
                0, 1:    return m_s2[b];
                2, 3:    return m_ddr[b];
                4, 5:    return m_sel[b][DW-1:0];
                6, 7:    return m_dbg[b];
                8, 9:    return m_sel[b][2*DW-1:DW];
                default: return '0;
            endcase
        end
        if (w < 8) return m_pat[w/2][b];
        return '0;
    endfunction

    task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d);
        int w, b;
        w = int'(a[4:1]);
        b = w % 2;
        if (!a[5]) begin
            case (w)
                0, 1: m_io[b] = d;
                2, 3: m_ddr[b] = d;
                4, 5: m_sel[b][DW-1:0] = d;
                6, 7: m_dbg[b] = d;
                8, 9: m_sel[b][2*DW-1:DW] = d;
                default: ;
            endcase
        end else if (w < 8) begin
            m_pat[w/2][b] = d;
        end
    endtask

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, check, then update the model at the rising edge
    task automatic cycle(string tag, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                         logic tx, logic rx, logic [DW-1:0] rxp, logic [DW-1:0] txp);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        tx_active = tx; rx_active = rx;
        rx_pin_in = rxp; tx_pin_in = txp;
        #1;
        check({tag, " R3 R4 R5 R6 R8 R11 rx_pin_out"}, rx_pin_out, exp_out(0));
        check({tag, " R3 R4 R5 R6 R8 R11 tx_pin_out"}, tx_pin_out, exp_out(1));
        check({tag, " R3 rx_pin_oe"}, rx_pin_oe, m_ddr[0]);
        check({tag, " R3 tx_pin_oe"}, tx_pin_oe, m_ddr[1]);
        if (!we) check({tag, " R9 R10 readback"}, bus_rdata, exp_read(a));
        @(posedge clk);
        if (we) model_write(a, d);
        m_state = state_of(tx, rx);
        m_s2[0] = m_s1[0]; m_s2[1] = m_s1[1];
        m_s1[0] = rxp;     m_s1[1] = txp;
    endtask

    task automatic wr(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
        cycle(tag, 1'b1, a, d, tx_active, rx_active, rx_pin_in, tx_pin_in);
    endtask

    task automatic rd_all(string tag);
        for (int a = 0; a < 64; a += 2)
            cycle(tag, 1'b0, AW'(a), '0, tx_active, rx_active, rx_pin_in, tx_pin_in);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd90210));
        model_reset();
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        rx_pin_in = 16'hFFFF; tx_pin_in = 16'hFFFF;
        #1;
        check("R1 rx_pin_oe in reset", rx_pin_oe, '0);
        check("R1 tx_pin_oe in reset", tx_pin_oe, '0);
        check("R1 rx_pin_out in reset", rx_pin_out, '0);
        check("R1 tx_pin_out in reset", tx_pin_out, '0);
        rx_pin_in = '0; tx_pin_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_all("R1 post-reset");

        // R2: odd byte address reaches the register below
        wr("R2 odd write", 6'd5, 16'hA5C3);
        cycle("R2 odd read", 1'b0, 6'd5, '0, 1'b0, 1'b0, '0, '0);
        cycle("R2 even read", 1'b0, 6'd4, '0, 1'b0, 1'b0, '0, '0);
        wr("R2 odd pattern", 6'h2B, 16'h0F0F);

        // R5 R7 R8: all pins on the pattern source, walk the radio states
        wr("R5 ddr", 6'h04, 16'hFFFF);
        wr("R5 ddr", 6'h06, 16'hFFFF);
        wr("R11 sel", 6'h08, 16'h5555);
        wr("R11 sel", 6'h0A, 16'h5555);
        wr("R11 sel", 6'h10, 16'h5555);
        wr("R11 sel", 6'h12, 16'h5555);
        for (int k = 0; k < 8; k++) wr("R7 pattern", AW'(6'h20 + 2*k), 16'h1111 * DW'(k + 1));
        foreach (m_pat[s, b]) ;
        for (int rep = 0; rep < 2; rep++) begin
            cycle("R7 R8 go-tx",     1'b0, 6'h00, '0, 1'b1, 1'b0, '0, '0);
            cycle("R7 R8 hold-tx",   1'b0, 6'h00, '0, 1'b1, 1'b0, '0, '0);
            cycle("R7 R8 go-rx",     1'b0, 6'h00, '0, 1'b0, 1'b1, '0, '0);
            cycle("R7 R8 go-duplex", 1'b0, 6'h00, '0, 1'b1, 1'b1, '0, '0);
            cycle("R7 R8 go-idle",   1'b0, 6'h00, '0, 1'b0, 1'b0, '0, '0);
        end

        // R6: debug codes 2 and 3, R3 with partial direction
        wr("R6 dbg", 6'h0C, 16'hC3A5);
        wr("R6 dbg", 6'h0E, 16'h5A3C);
        wr("R6 sel lo", 6'h08, 16'hAAAA);
        wr("R6 sel hi", 6'h10, 16'hFFFF);
        wr("R6 sel lo", 6'h0A, 16'hFAFA);
        wr("R3 ddr", 6'h04, 16'h00FF);
        cycle("R6 check", 1'b0, 6'h0C, '0, 1'b0, 1'b0, '0, '0);

        // R10: unused slots change nothing
        wr("R10 unused", 6'h14, 16'hFFFF);
        wr("R10 unused", 6'h1E, 16'hFFFF);
        wr("R10 unused", 6'h32, 16'hFFFF);
        wr("R10 unused", 6'h3F, 16'hFFFF);
        rd_all("R10 after unused writes");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic          we;
            logic [AW-1:0] a;
            logic          tx, rx;
            we = ($urandom % 3) == 0;
            a  = AW'($urandom);
            tx = tx_active; rx = rx_active;
            if (($urandom % 4) == 0) begin
                tx = 1'($urandom); rx = 1'($urandom);
            end
            cycle("random", we, a, DW'($urandom), tx, rx, DW'($urandom), DW'($urandom));
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule